// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

The filter decides, once per received frame, whether the frame's 48-bit destination address should be accepted. It holds a bank of exact-match address slots, a 64-bin multicast hash table and three mode flags: promiscuous, broadcast reject and hash enable. A programmable count of the lowest slots is kept for unicast addresses. The remaining slots only match group (multicast) addresses. Any multicast address that does not fit in a slot is caught through the hash table.

A simple 32-bit register write port loads the slot words, the two hash words and the mode word. The receive path presents each destination address with a one-cycle valid strobe. One clock later the filter returns a decision strobe, an accept flag and a one-hot reason code.

The destination address vector carries byte k of the address in bits 8k+7..8k, with byte 0 being the first octet on the wire. Bit 0 of the vector is therefore the group bit.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, every slot is disarmed, both hash words are zero, all mode flags are clear and the unicast count is 0. While reset is held, decValid, accept and reason are all 0.
- R2: decValid is 1 exactly in the cycle after a cycle with addrValid=1. When decValid is 0, accept and reason are 0. When decValid is 1, accept is 1 exactly when reason is non-zero.
- R3: An armed slot hits when dstAddr[31:0] equals its low word and dstAddr[47:32] equals bits 15..0 of its high word. A hit is reported with accept=1 and reason=4'b0001.
- R4: A write to a slot's low word disarms that slot. A later write to the same slot's high word arms it again.
- R5: Slots with an index below the unicast count match only addresses with dstAddr[0]=0. Slots at or above the count match only addresses with dstAddr[0]=1. A written count above NUM_SLOTS is stored as NUM_SLOTS.
- R6: Bit i of the 6-bit hash index is the XOR of every dstAddr bit j with j mod 6 = i. This is the same as walking bytes 0 to 5, each byte LSB first, with a bit position that wraps from 5 back to 0.
- R7: The hash table is made of two words. Index n below 32 selects bit n of the low word, and index n of 32 or more selects bit n-32 of the high word. A hash hit needs hash enable, dstAddr[0]=1 and a set table bit. It gives accept=1 and reason=4'b0010.
- R8: The all-ones address, when not in promiscuous mode, gives accept=1 and reason=4'b0100 if broadcast reject is clear. If broadcast reject is set it gives accept=0 and reason=0, whatever the slot and hash contents.
- R9: In promiscuous mode every address gives accept=1 and reason=4'b1000.
- R10: Reason is one-hot or zero. The priority order is promiscuous, then broadcast, then exact, then hash.
- R11: Register map for word address a: 2i is the low word of slot i and 2i+1 is its high word, for i below NUM_SLOTS. 2*NUM_SLOTS is the hash low word and 2*NUM_SLOTS+1 is the hash high word. 2*NUM_SLOTS+2 is the mode word: bit 0 promiscuous, bit 1 broadcast reject, bit 2 hash enable, bits 8 and up the unicast count. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register word address |
| wrData | input | 32 | Register write data |
| addrValid | input | 1 | Destination address present this cycle |
| dstAddr | input | 48 | Destination address, byte 0 in bits 7..0 |
| decValid | output | 1 | Decision present this cycle |
| accept | output | 1 | Frame accepted |
| reason | output | 4 | One-hot reason: 0 exact, 1 hash, 2 broadcast, 3 promiscuous |

## Verification
The bench builds the filter with the default of eight slots, which gives a 5-bit register address and a 4-bit unicast count field. With that field, counts from 9 to 15 can be written, so the clamp to eight can be tested. Writes to the unused addresses 19 to 31 can be issued and checked as ignored. Every slot can also be moved across the unicast/multicast boundary by changing the count.

// File: rtl/af_pkg.sv
package af_pkg;

  localparam int MODE_PROMISC = 0;
  localparam int MODE_BCDIS   = 1;
  localparam int MODE_HASHEN  = 2;
  localparam int MODE_UC_LSB  = 8;

  localparam logic [3:0] RSN_NONE    = 4'b0000;
  localparam logic [3:0] RSN_EXACT   = 4'b0001;
  localparam logic [3:0] RSN_HASH    = 4'b0010;
  localparam logic [3:0] RSN_BCAST   = 4'b0100;
  localparam logic [3:0] RSN_PROMISC = 4'b1000;

  typedef struct packed {
    logic       slotLoWr;
    logic       slotHiWr;
    logic [7:0] slotSel;
    logic       hashLoWr;
    logic       hashHiWr;
    logic       modeWr;
    logic       capture;
  } afStrobes_t;

endpackage

// File: rtl/af_ctrl.sv
module af_ctrl
  import af_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ADDR_W    = 5
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              addrValid,
  output afStrobes_t        strb
);

  localparam int SLOT_WORDS = 2 * NUM_SLOTS;
  localparam int HASH_LO_A  = SLOT_WORDS;
  localparam int HASH_HI_A  = SLOT_WORDS + 1;
  localparam int MODE_A     = SLOT_WORDS + 2;

  always_comb begin
    strb          = '0;
    strb.capture  = addrValid;
    strb.slotSel  = 8'(wrAddr >> 1);
    if (wrEn) begin
      if (int'(wrAddr) < SLOT_WORDS) begin
        strb.slotLoWr = ~wrAddr[0];
        strb.slotHiWr = wrAddr[0];
      end else if (int'(wrAddr) == HASH_LO_A) begin
        strb.hashLoWr = 1'b1;
      end else if (int'(wrAddr) == HASH_HI_A) begin
        strb.hashHiWr = 1'b1;
      end else if (int'(wrAddr) == MODE_A) begin
        strb.modeWr = 1'b1;
      end
    end
  end

endmodule

// File: rtl/af_datapath.sv
module af_datapath
  import af_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  afStrobes_t  strb,
  input  logic [31:0] wrData,
  input  logic [47:0] dstAddr,
  output logic        decValid,
  output logic        accept,
  output logic [3:0]  reason
);

  localparam int UC_W = $clog2(NUM_SLOTS + 1);

  function automatic logic [47:0] foldMask(input int pos);
    logic [47:0] m;
    m = '0;
    for (int j = 0; j < 48; j++) m[j] = ((j % 6) == pos);
    return m;
  endfunction

  logic [31:0]          slotLo [NUM_SLOTS];
  logic [15:0]          slotHi [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] armed;
  logic [NUM_SLOTS-1:0] slotHit;
  logic [63:0]          hashTbl;
  logic                 promisc, bcDis, hashEn;
  logic [UC_W-1:0]      ucCount;
  logic [UC_W-1:0]      ucReq;
  logic [5:0]           hashIdx;
  logic                 isBcast, isGroup, hashHit;
  logic [3:0]           nxtReason;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slotLo[s] <= '0;
        slotHi[s] <= '0;
        armed[s]  <= 1'b0;
      end else if (int'(strb.slotSel) == s) begin
        if (strb.slotLoWr) begin
          slotLo[s] <= wrData;
          armed[s]  <= 1'b0;
        end
        if (strb.slotHiWr) begin
          slotHi[s] <= wrData[15:0];
          armed[s]  <= 1'b1;
        end
      end
    end

    assign slotHit[s] = armed[s] &&
                        (slotLo[s] == dstAddr[31:0]) &&
                        (slotHi[s] == dstAddr[47:32]) &&
                        ((UC_W'(s) < ucCount) ? ~isGroup : isGroup);
  end

  for (genvar b = 0; b < 6; b++) begin : g_fold
    assign hashIdx[b] = ^(dstAddr & foldMask(b));
  end

  assign ucReq = wrData[MODE_UC_LSB +: UC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      hashTbl <= '0;
      promisc <= 1'b0;
      bcDis   <= 1'b0;
      hashEn  <= 1'b0;
      ucCount <= '0;
    end else begin
      if (strb.hashLoWr) hashTbl[31:0]  <= wrData;
      if (strb.hashHiWr) hashTbl[63:32] <= wrData;
      if (strb.modeWr) begin
        promisc <= wrData[MODE_PROMISC];
        bcDis   <= wrData[MODE_BCDIS];
        hashEn  <= wrData[MODE_HASHEN];
        ucCount <= (ucReq > UC_W'(NUM_SLOTS)) ? UC_W'(NUM_SLOTS) : ucReq;
      end
    end
  end

  assign isBcast = &dstAddr;
  assign isGroup = dstAddr[0];
  assign hashHit = hashEn && isGroup && hashTbl[hashIdx];

  always_comb begin
    if (promisc)        nxtReason = RSN_PROMISC;
    else if (isBcast)   nxtReason = bcDis ? RSN_NONE : RSN_BCAST;
    else if (|slotHit)  nxtReason = RSN_EXACT;
    else if (hashHit)   nxtReason = RSN_HASH;
    else                nxtReason = RSN_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      decValid <= 1'b0;
      accept   <= 1'b0;
      reason   <= RSN_NONE;
    end else begin
      decValid <= strb.capture;
      accept   <= strb.capture && (nxtReason != RSN_NONE);
      reason   <= strb.capture ? nxtReason : RSN_NONE;
    end
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import af_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int ADDR_W   = $clog2(2 * NUM_SLOTS + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              addrValid,
  input  logic [47:0]       dstAddr,
  output logic              decValid,
  output logic              accept,
  output logic [3:0]        reason
);

  afStrobes_t strb;

  af_ctrl #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .addrValid (addrValid),
    .strb      (strb)
  );

  af_datapath #(.NUM_SLOTS(NUM_SLOTS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .wrData   (wrData),
    .dstAddr  (dstAddr),
    .decValid (decValid),
    .accept   (accept),
    .reason   (reason)
  );

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
  input logic        clk,
  input logic        rst,
  input logic        addrValid,
  input logic [47:0] dstAddr,
  input logic        decValid,
  input logic        accept,
  input logic [3:0]  reason
);

  AST_DECISION_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    addrValid |=> decValid); // R2

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !addrValid |=> (!decValid && !accept && reason == 4'b0000)); // R2

  AST_ACCEPT_HAS_REASON: assert property (@(posedge clk) disable iff (rst)
    accept |-> (reason != 4'b0000)); // R2

  AST_REASON_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reason)); // R10

  AST_BCAST_NOT_FILTERED: assert property (@(posedge clk) disable iff (rst)
    (addrValid && (&dstAddr)) |=> (!reason[0] && !reason[1])); // R8

  AST_UNICAST_NO_HASH: assert property (@(posedge clk) disable iff (rst)
    (addrValid && !dstAddr[0]) |=> !reason[1]); // R7

endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .addrValid (addrValid),
  .dstAddr   (dstAddr),
  .decValid  (decValid),
  .accept    (accept),
  .reason    (reason)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;

  localparam int NS     = 8;
  localparam int AW     = 5;
  localparam int A_HLO  = 2 * NS;
  localparam int A_HHI  = 2 * NS + 1;
  localparam int A_MODE = 2 * NS + 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        addrValid = 1'b0;
  logic [47:0] dstAddr = '0;
  logic        decValid, accept;
  logic [3:0]  reason;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  rx_addr_filter #(.NUM_SLOTS(NS)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .addrValid(addrValid), .dstAddr(dstAddr),
    .decValid(decValid), .accept(accept), .reason(reason)
  );

  // reference model state
  logic [31:0] mLo [NS];
  logic [15:0] mHi [NS];
  bit          mArm [NS];
  logic [63:0] mTbl;
  bit          mProm, mBcDis, mHashEn;
  int          mUc;
  bit          eValid, eAcc;
  logic [3:0]  eRsn;

  function automatic int hashOf(input logic [47:0] a);
    int pos = 0;
    logic [5:0] h = '0;
    for (int o = 0; o < 6; o++)
      for (int b = 0; b < 8; b++) begin
        h[pos] = h[pos] ^ a[8*o+b];
        pos = (pos == 5) ? 0 : pos + 1;
      end
    return int'(h);
  endfunction

  function automatic logic [3:0] modelReason(input logic [47:0] a);
    bit grp = a[0];
    if (mProm) return 4'b1000;
    if (a == {48{1'b1}}) return mBcDis ? 4'b0000 : 4'b0100;
    for (int s = 0; s < NS; s++)
      if (mArm[s] && mLo[s] == a[31:0] && mHi[s] == a[47:32] &&
          ((s < mUc) ? !grp : grp)) return 4'b0001;
    if (mHashEn && grp && mTbl[hashOf(a)]) return 4'b0010;
    return 4'b0000;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int s = 0; s < NS; s++) begin mLo[s] = '0; mHi[s] = '0; mArm[s] = 0; end
      mTbl = '0; mProm = 0; mBcDis = 0; mHashEn = 0; mUc = 0;
      eValid = 0; eAcc = 0; eRsn = '0;
    end else begin
      eValid = addrValid;
      eRsn   = addrValid ? modelReason(dstAddr) : 4'b0000;
      eAcc   = (eRsn != 4'b0000);
      if (wrEn) begin
        if (int'(wrAddr) < 2 * NS) begin
          if (wrAddr[0]) begin mHi[wrAddr >> 1] = wrData[15:0]; mArm[wrAddr >> 1] = 1; end
          else begin mLo[wrAddr >> 1] = wrData; mArm[wrAddr >> 1] = 0; end
        end else if (int'(wrAddr) == A_HLO) mTbl[31:0] = wrData;
        else if (int'(wrAddr) == A_HHI) mTbl[63:32] = wrData;
        else if (int'(wrAddr) == A_MODE) begin
          mProm = wrData[0]; mBcDis = wrData[1]; mHashEn = wrData[2];
          mUc = int'(wrData[11:8]);
          if (mUc > NS) mUc = NS;
        end
      end
    end
  end

  always @(negedge clk) begin
    string req;
    if (rst) req = "R1";
    else if (!eValid) req = "R2";
    else case (eRsn)
      4'b1000: req = "R9";
      4'b0100: req = "R8";
      4'b0010: req = "R7";
      4'b0001: req = "R3";
      default: req = "R5";
    endcase
    checks++;
    if (decValid !== eValid || accept !== eAcc || reason !== eRsn) begin
      fails++;
      $display("FAIL %s: got valid=%0b acc=%0b rsn=%b, expected valid=%0b acc=%0b rsn=%b",
               req, decValid, accept, reason, eValid, eAcc, eRsn);
    end
  end

  task automatic cyc(input bit we, input int a, input logic [31:0] d,
                     input bit av, input logic [47:0] da);
    @(negedge clk);
    wrEn = we; wrAddr = AW'(a); wrData = d; addrValid = av; dstAddr = da;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cyc(1, a, d, 0, '0);
  endtask

  task automatic probe(input logic [47:0] da);
    cyc(0, 0, '0, 1, da);
  endtask

  task automatic setSlot(input int s, input logic [47:0] da);
    wr(2 * s, da[31:0]);
    wr(2 * s + 1, {16'h0, da[47:32]});
  endtask

  localparam logic [47:0] UNI_A = 48'h5544_3322_1100;
  localparam logic [47:0] MC_A  = 48'h0605_0403_0201;
  localparam logic [47:0] MC_B  = 48'h1a2b_3c4d_5e01;
  localparam logic [47:0] BC    = {48{1'b1}};

  initial begin
    logic [47:0] hiAddr;
    int h;
    repeat (4) @(negedge clk);               // R1 checked while reset held
    rst = 1'b0;
    probe(UNI_A); probe(MC_A); probe(BC);    // R1 empty filter, R8 default broadcast
    wr(A_MODE, 32'h0000_0100);               // R11 unicast count 1
    setSlot(0, UNI_A); setSlot(3, MC_A);
    probe(UNI_A); probe(MC_A); probe(MC_B);  // R3
    wr(0, UNI_A[31:0]); probe(UNI_A);        // R4 disarmed after low write
    wr(1, {16'h0, UNI_A[47:32]}); probe(UNI_A); // R4 rearmed
    setSlot(5, UNI_A ^ 48'h1); probe(UNI_A ^ 48'h1); // R5 multicast slot, group addr
    setSlot(6, UNI_A ^ 48'h100); probe(UNI_A ^ 48'h100); // R5 unicast in multicast slot
    wr(A_MODE, 32'h0000_0f00);               // R5 clamp to NS
    probe(MC_A); probe(UNI_A ^ 48'h100);
    wr(A_MODE, 32'h0000_0104);               // R7 hash enabled
    h = hashOf(MC_B);                        // R6 index fold
    if (h < 32) wr(A_HLO, 32'h1 << h); else wr(A_HHI, 32'h1 << (h - 32));
    probe(MC_B); probe(MC_B ^ 48'h1);        // R7 unicast twin rejected
    hiAddr = 48'h0100_0000_0001;
    for (int k = 0; k < 64 && hashOf(hiAddr) < 32; k++) hiAddr = hiAddr + 48'h100;
    wr(A_HHI, 32'h1 << (hashOf(hiAddr) - 32)); probe(hiAddr); // R7 high word bin
    wr(A_HLO, 32'hffff_ffff); wr(A_HHI, 32'hffff_ffff); probe(MC_B); // R7 all-multicast
    setSlot(4, BC); probe(BC);               // R8
    wr(A_MODE, 32'h0000_0106); probe(BC); probe(MC_A); // R8 reject, R10 exact over hash
    wr(A_MODE, 32'h0000_0107); probe(BC); probe(48'h0); // R9
    cyc(1, 25, 32'hffff_ffff, 1, 48'h0);     // R11 unused address ignored
    wr(A_MODE, 32'h0); probe(48'h0);
    for (int i = 0; i < 3000; i++) begin
      logic [47:0] pool [4];
      pool[0] = UNI_A; pool[1] = MC_A; pool[2] = MC_B; pool[3] = BC;
      cyc($urandom_range(0, 3) == 0, int'($urandom_range(0, 31)),
          ($urandom_range(0, 1) == 0) ? $urandom : ($urandom & 32'h0000_0f03),
          $urandom_range(0, 2) != 0,
          ($urandom_range(0, 2) == 0) ? {$urandom, $urandom} & 48'hffff_ffff_ffff
                                      : pool[$urandom_range(0, 3)] ^ 48'($urandom_range(0, 1)));
    end
    cyc(0, 0, '0, 0, '0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got cycles=%0d, expected under 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule